// File: doc/BRIEF.md
# Clock-State Synchronization Receiver

This block keeps a shared internal clock-state counter in lock with an external synchronization pulse train so that several devices fed by the same sync signal hold identical clock states. The counter advances by one on every system-clock cycle and wraps with a period of 2^STATE_W cycles (16 by default). Its bits are also the divided internal clocks.

The incoming sync signal is first brought into the clock domain by a flop synchronizer. It then passes a programmable delay line, and its rising edge is detected there. When the receiver is enabled, a detected edge reloads the counter with a programmable preset state. Once the counter has been aligned, every later edge is checked against an expected arrival window. An edge outside the window raises a sticky error flag. The flag is cleared by a write-one-to-clear pulse, and the check can be bypassed.

With the receiver disabled, the counter runs freely and sync edges are ignored. Disabling also drops alignment, so the first edge after re-enabling only realigns the counter.

Top module: `clkstate_sync_rx`

## Requirements
- R1: Without a qualified sync edge, `clk_state` advances by one modulo 16 on every rising clock edge.
- R2: `div_clk[k]` is counter bit k, so over 32 free-running cycles bit 0 toggles 32 times, bit 1 16 times, bit 2 8 times and bit 3 4 times.
- R3: With `in_delay` = D (0 to 7), a `sync_in` that is first sampled high at a clock edge makes `clk_state` equal `preset_state` right after the (D+3)th rising edge, counted from that sampling edge. Before that edge the counter keeps counting normally.
- R4: While `rx_enable` is 0, sync edges have no effect and the counter keeps counting.
- R5: Only a 0-to-1 transition of the delayed sync signal reloads the counter. A level held high and a falling edge do not.
- R6: The first qualified edge after reset never sets `sync_err`. Reset clears the synchronizer and edge history, so a `sync_in` already high at reset release counts as a rising edge.
- R7: An edge on an aligned receiver sets `sync_err` if (`clk_state` + `val_delay`) mod 16 differs from (`preset_state` − 1) mod 16 in the cycle the edge is detected. The flag rises at the same clock edge that reloads the counter. With `val_delay` = 0, edges spaced 13 cycles apart are out of window.
- R8: With `val_delay` = 0, sync pulses spaced exactly 16 cycles apart never set `sync_err`.
- R9: While `val_disable` is 1, no edge sets `sync_err`, and edges still reload the counter.
- R10: `sync_err` stays set until a cycle with `err_clear` = 1, which clears it. When a new error and `err_clear` fall in the same cycle, the flag stays set.
- R11: Asynchronous reset (`rst_n` = 0) forces `clk_state`, `div_clk` and `sync_err` to 0.
- R12: With `val_delay` = 3, pulses spaced 13 cycles apart pass the check, and a pulse spaced 16 cycles after the previous one sets `sync_err`.
- R13: Dropping `rx_enable` clears alignment. The first edge after re-enabling never sets `sync_err`, and later edges are checked again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_in | input | 1 | External synchronization pulse train |
| rx_enable | input | 1 | Enables edge-driven realignment and checking |
| preset_state | input | 4 | State loaded on a qualified sync edge |
| in_delay | input | 3 | Delay of the synchronized input in clock cycles |
| val_delay | input | 4 | Offset added to the state before the window compare |
| val_disable | input | 1 | Bypasses the arrival-window check |
| err_clear | input | 1 | Write-one-to-clear pulse for the error flag |
| clk_state | output | 4 | Current clock state |
| div_clk | output | 4 | Divided clocks: clk/2, /4, /8, /16 |
| sync_err | output | 1 | Sticky sync sampling error flag |

## Verification
Single pulses at delays 0, 3 and 7 pin down the exact reload cycle. Because the preset is changed one cycle before the load takes effect, a reload that comes one cycle early or late cannot go unnoticed. Pulse trains spaced 16 and 13 cycles apart are run with zero and non-zero window offsets, which separates a correct modular window compare from a fixed-period check and from an offset that is ignored or applied with the wrong sign. Held-high levels, falling edges, a disabled receiver and a re-enable mid-train show whether the edge qualification and the alignment tracking are present. An error raised in the same cycle as a clear shows which of the two takes precedence.

// File: rtl/clkstate_pkg.sv
package clkstate_pkg;
  localparam int unsigned STATE_W_DEF     = 4;
  localparam int unsigned DLY_W_DEF       = 3;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // Outcome of inspecting one qualified sync edge
  typedef enum logic [1:0] {
    CHK_NONE  = 2'd0,
    CHK_ALIGN = 2'd1,
    CHK_HIT   = 2'd2,
    CHK_MISS  = 2'd3
  } chk_e;
endpackage

// File: rtl/clkstate_in_path.sv
module clkstate_in_path #(
  parameter int unsigned DLY_W       = clkstate_pkg::DLY_W_DEF,
  parameter int unsigned SYNC_STAGES = clkstate_pkg::SYNC_STAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [DLY_W-1:0] dly_sel,
  output logic             edge_det
);
  localparam int unsigned TAPS = (1 << DLY_W) - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic [TAPS-1:0]        line_q;
  logic [TAPS-1:0]        line_d;
  logic [TAPS:0]          taps_all;
  logic                   synced;
  logic                   tap;
  logic                   hist_q;
  logic                   hist_d;

  // Metastability chain
  assign sync_d[0] = sync_in;
  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    assign sync_d[i] = sync_q[i-1];
  end
  assign synced = sync_q[SYNC_STAGES-1];

  // Whole-cycle delay line
  if (TAPS > 1) begin : g_line
    assign line_d = {line_q[TAPS-2:0], synced};
  end else begin : g_line1
    assign line_d = synced;
  end

  // Tap 0 is the synchronizer output itself
  assign taps_all = {line_q, synced};

  always_comb begin
    tap      = taps_all[dly_sel];
    hist_d   = tap;
    edge_det = tap & ~hist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      line_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      line_q <= line_d;
      hist_q <= hist_d;
    end
  end
endmodule

// File: rtl/clkstate_gen.sv
module clkstate_gen #(
  parameter int unsigned STATE_W = clkstate_pkg::STATE_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [STATE_W-1:0] preset,
  output logic [STATE_W-1:0] state,
  output logic [STATE_W-1:0] div_clk
);
  localparam logic [STATE_W-1:0] STEP = STATE_W'(1);

  logic [STATE_W-1:0] cnt_q;
  logic [STATE_W-1:0] cnt_d;

  always_comb begin
    if (load) cnt_d = preset;
    else      cnt_d = cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign state = cnt_q;

  // Bit k of the state toggles at clk / 2^(k+1)
  for (genvar k = 0; k < STATE_W; k++) begin : g_div
    assign div_clk[k] = cnt_q[k];
  end
endmodule

// File: rtl/clkstate_validate.sv
module clkstate_validate
  import clkstate_pkg::*;
#(
  parameter int unsigned STATE_W = STATE_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               edge_hit,
  input  logic               chk_off,
  input  logic [STATE_W-1:0] cur_state,
  input  logic [STATE_W-1:0] preset,
  input  logic [STATE_W-1:0] win_ofs,
  input  logic               err_clr,
  output logic               err_flag
);
  localparam logic [STATE_W-1:0] STEP = STATE_W'(1);

  logic [STATE_W-1:0] probe;
  logic [STATE_W-1:0] target;
  chk_e               verdict;
  logic               aligned_q;
  logic               aligned_d;
  logic               err_q;
  logic               err_d;
  logic               err_en;
  logic               err_set;

  always_comb begin
    probe  = cur_state + win_ofs;
    target = preset - STEP;
    if (!edge_hit)                       verdict = CHK_NONE;
    else if (!aligned_q)                 verdict = CHK_ALIGN;
    else if (chk_off || probe == target) verdict = CHK_HIT;
    else                                 verdict = CHK_MISS;

    aligned_d = rx_en ? (aligned_q | edge_hit) : 1'b0;
    err_set   = (verdict == CHK_MISS);
    err_en    = err_set | err_clr;
    err_d     = err_set;        // a new miss outranks a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      aligned_q <= aligned_d;
      if (err_en) err_q <= err_d;
    end
  end

  assign err_flag = err_q;
endmodule

// File: rtl/clkstate_sync_rx.sv
module clkstate_sync_rx #(
  parameter int unsigned STATE_W     = clkstate_pkg::STATE_W_DEF,
  parameter int unsigned DLY_W       = clkstate_pkg::DLY_W_DEF,
  parameter int unsigned SYNC_STAGES = clkstate_pkg::SYNC_STAGES_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_in,
  input  logic               rx_enable,
  input  logic [STATE_W-1:0] preset_state,
  input  logic [DLY_W-1:0]   in_delay,
  input  logic [STATE_W-1:0] val_delay,
  input  logic               val_disable,
  input  logic               err_clear,
  output logic [STATE_W-1:0] clk_state,
  output logic [STATE_W-1:0] div_clk,
  output logic               sync_err
);
  logic edge_det;
  logic qual_edge;

  clkstate_in_path #(
    .DLY_W       (DLY_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_in_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_in),
    .dly_sel  (in_delay),
    .edge_det (edge_det)
  );

  assign qual_edge = edge_det & rx_enable;

  clkstate_gen #(
    .STATE_W (STATE_W)
  ) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (qual_edge),
    .preset  (preset_state),
    .state   (clk_state),
    .div_clk (div_clk)
  );

  clkstate_validate #(
    .STATE_W (STATE_W)
  ) u_validate (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_enable),
    .edge_hit  (qual_edge),
    .chk_off   (val_disable),
    .cur_state (clk_state),
    .preset    (preset_state),
    .win_ofs   (val_delay),
    .err_clr   (err_clear),
    .err_flag  (sync_err)
  );
endmodule

// File: rtl/clkstate_sync_rx_chk.sv
module clkstate_sync_rx_chk #(
  parameter int unsigned STATE_W = clkstate_pkg::STATE_W_DEF
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_enable,
  input logic [STATE_W-1:0] preset_state,
  input logic               val_disable,
  input logic               err_clear,
  input logic [STATE_W-1:0] clk_state,
  input logic               sync_err,
  input logic               qual_edge
);
  localparam logic [STATE_W-1:0] STEP = STATE_W'(1);

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_edge |=> clk_state == STATE_W'($past(clk_state) + STEP));

  p_load_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qual_edge |=> clk_state == $past(preset_state));

  p_disabled_free_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> clk_state == STATE_W'($past(clk_state) + STEP));

  p_err_needs_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_err && !qual_edge |=> !sync_err);

  p_bypass_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    val_disable && !sync_err |=> !sync_err);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err && !err_clear |=> sync_err);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear && !qual_edge |=> !sync_err);
endmodule

bind clkstate_sync_rx clkstate_sync_rx_chk #(.STATE_W(STATE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_enable    (rx_enable),
  .preset_state (preset_state),
  .val_disable  (val_disable),
  .err_clear    (err_clear),
  .clk_state    (clk_state),
  .sync_err     (sync_err),
  .qual_edge    (qual_edge)
);

// File: tb/clkstate_sync_rx_tb_top.sv
module clkstate_sync_rx_tb_top;
  logic       clk;
  logic       rst_n;
  logic       sync_in;
  logic       rx_enable;
  logic [3:0] preset_state;
  logic [2:0] in_delay;
  logic [3:0] val_delay;
  logic       val_disable;
  logic       err_clear;
  logic [3:0] clk_state;
  logic [3:0] div_clk;
  logic       sync_err;

  int tests;
  int fails;

  clkstate_sync_rx dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_in      (sync_in),
    .rx_enable    (rx_enable),
    .preset_state (preset_state),
    .in_delay     (in_delay),
    .val_delay    (val_delay),
    .val_disable  (val_disable),
    .err_clear    (err_clear),
    .clk_state    (clk_state),
    .div_clk      (div_clk),
    .sync_err     (sync_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts cycles in which the state did not step by exactly one
  task automatic count_steps(input int n, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      logic [3:0] a;
      a = clk_state;
      @(negedge clk);
      if (clk_state != 4'(a + 4'd1)) bad++;
    end
  endtask

  task automatic clear_err();
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    @(negedge clk);
  endtask

  task automatic drop_align();
    rx_enable = 1'b0;
    @(negedge clk);
    rx_enable = 1'b1;
    @(negedge clk);
  endtask

  // One pulse, two cycles high, the next pulse starts gap cycles later
  task automatic pulse_gap(input int gap);
    sync_in = 1'b1;
    idle(2);
    sync_in = 1'b0;
    idle(gap - 2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sync_in = 1'b1; rx_enable = 1'b1; preset_state = 4'd9;
    in_delay = 3'd0; val_delay = 4'd0; val_disable = 1'b0; err_clear = 1'b0;
    idle(3);
    chk("R11 state in reset", clk_state, 0);
    chk("R11 div_clk in reset", div_clk, 0);
    chk("R11 sync_err in reset", sync_err, 0);
    rst_n = 1'b1;
    @(negedge clk); chk("R1 first step", clk_state, 1);
    @(negedge clk); chk("R1 second step", clk_state, 2);
    @(negedge clk); chk("R11 level high at release reloads", clk_state, 9);
    @(negedge clk); chk("R6 first edge no error", sync_err, 0);
    sync_in = 1'b0;
    idle(12);
  endtask

  task automatic t_latency(input int d);
    logic [3:0] v;
    int bad;
    in_delay = 3'(d); val_disable = 1'b1; rx_enable = 1'b1; sync_in = 1'b0;
    idle(12);
    sync_in = 1'b1;
    idle(d + 1);
    v = clk_state;
    preset_state = 4'(v + 4'd8);
    @(negedge clk); chk($sformatf("R3 no early load d=%0d", d), clk_state, 4'(v + 4'd1));
    @(negedge clk); chk($sformatf("R3 load at d+3 d=%0d", d), clk_state, 4'(v + 4'd8));
    @(negedge clk); chk($sformatf("R1 step after load d=%0d", d), clk_state, 4'(v + 4'd9));
    count_steps(16, bad);
    chk($sformatf("R5 held level no reload d=%0d", d), bad, 0);
    sync_in = 1'b0;
    count_steps(16, bad);
    chk($sformatf("R5 falling edge no reload d=%0d", d), bad, 0);
    val_disable = 1'b0;
  endtask

  task automatic t_disabled();
    int bad;
    rx_enable = 1'b0; sync_in = 1'b0;
    idle(2);
    sync_in = 1'b1;
    idle(3);
    sync_in = 1'b0;
    count_steps(24, bad);
    chk("R4 disabled ignores edges", bad, 0);
    chk("R4 no error while disabled", sync_err, 0);
  endtask

  task automatic t_dividers();
    int tog [4];
    logic [3:0] prev;
    rx_enable = 1'b0;
    for (int k = 0; k < 4; k++) tog[k] = 0;
    prev = div_clk;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) if (div_clk[k] != prev[k]) tog[k]++;
      prev = div_clk;
    end
    for (int k = 0; k < 4; k++)
      chk($sformatf("R2 div bit %0d toggles", k), tog[k], 32 >> k);
    rx_enable = 1'b1;
  endtask

  // Pulse spaced after the previous one; checks the flag around its load
  task automatic miss_pulse(input int gap_after, input bit clr_same);
    int d;
    d = int'(in_delay);
    sync_in = 1'b1;
    for (int k = 1; k <= gap_after; k++) begin
      if (clr_same && k == d + 2) err_clear = 1'b1;
      @(negedge clk);
      if (k == 2) sync_in = 1'b0;
      if (k == d + 2 && !clr_same) chk("R7 no error before load", sync_err, 0);
      if (k == d + 3) begin
        if (clr_same) chk("R10 set wins over clear", sync_err, 1);
        else          chk("R7 miss sets error at load", sync_err, 1);
        err_clear = 1'b0;
      end
    end
  endtask

  task automatic t_window();
    in_delay = 3'd2; preset_state = 4'd5; val_delay = 4'd0; val_disable = 1'b0;
    rx_enable = 1'b1; sync_in = 1'b0;
    idle(12);
    drop_align();
    clear_err();
    repeat (4) pulse_gap(16);
    idle(12);
    chk("R8 16-cycle train no error", sync_err, 0);
    drop_align();
    repeat (3) pulse_gap(16);
    pulse_gap(13);
    miss_pulse(13, 1'b0);
    miss_pulse(13, 1'b1);
    idle(20);
    chk("R10 error sticky", sync_err, 1);
    clear_err();
    chk("R10 clear pulse clears", sync_err, 0);
  endtask

  task automatic t_valdelay();
    val_delay = 4'd3;
    idle(12);
    drop_align();
    clear_err();
    repeat (5) pulse_gap(13);
    chk("R12 13-cycle train passes with offset 3", sync_err, 0);
    pulse_gap(16);
    pulse_gap(16);
    chk("R12 16-cycle spacing fails with offset 3", sync_err, 1);
    val_delay = 4'd0;
    idle(12);
    clear_err();
  endtask

  task automatic t_bypass();
    logic [3:0] v;
    val_disable = 1'b1; preset_state = 4'd11;
    drop_align();
    repeat (4) pulse_gap(11);
    chk("R9 bypass suppresses error", sync_err, 0);
    sync_in = 1'b1;
    idle(int'(in_delay) + 3);
    sync_in = 1'b0;
    v = clk_state;
    chk("R9 bypass still reloads", v, 11);
    idle(12);
    val_disable = 1'b0;
    clear_err();
  endtask

  task automatic t_realign();
    drop_align();
    repeat (2) pulse_gap(16);
    idle(3);
    drop_align();
    pulse_gap(16);
    chk("R13 first edge after re-enable no error", sync_err, 0);
    pulse_gap(9);
    pulse_gap(16);
    chk("R13 checking resumes after realign", sync_err, 1);
    clear_err();
  endtask

  initial begin
    tests = 0;
    fails = 0;
    rst_n = 1'b0;
    sync_in = 1'b0; rx_enable = 1'b0; preset_state = 4'd0; in_delay = 3'd0;
    val_delay = 4'd0; val_disable = 1'b0; err_clear = 1'b0;
    t_reset();
    t_latency(0);
    t_latency(3);
    t_latency(7);
    t_disabled();
    t_dividers();
    t_window();
    t_valdelay();
    t_bypass();
    t_realign();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule